// File: doc/BRIEF.md
# Phase-Accumulator Serial Clock Generator

This block derives a serial-interface clock from a faster reference clock, for use under a transfer sequencer and next to a data shifter. On every reference cycle in which a transfer is running, a fractional phase accumulator with a modulus of 2048 adds a 16-bit rate word. Each time the sum reaches or passes the modulus, the internal clock phase flips, so the serial clock makes one half-period step. A rate word of 2048 therefore flips the clock on every reference cycle. A smaller word N gives an average of N/2048 half-periods per cycle.

The visible clock level is the internal phase combined with a global polarity bit, so the clock rests at the polarity level whenever no transfer runs. Two per-profile bits choose whether the data launch strobe and the data latch strobe follow the rising or the falling clock transition. Each strobe is a single reference-cycle enable that is high in the cycle right after the chosen transition. A per-profile bit can make the sequencer's loop-start pulse clear the accumulator, so that every loop starts with the same phase. Two further profile bits are only registered and passed on: one selects the asynchronous receive sampling path and the other flags double-rate mode. The rule that the asynchronous path is used for serial clocks above 30 MHz is left to the software that programs the profile.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is asserted, sclk equals cpol, launch_en and latch_en are 0, and rx_async_path and dbl_rate_mode are 0.
- R2: On each clock edge with run high, the accumulator adds the step. When the sum is 2048 or more, 2048 is subtracted and sclk changes level at that same edge. From a cleared accumulator, n running cycles give floor(n*step/2048) sclk transitions.
- R3: The step equals freq_word, limited to 2048. A freq_word above 2048 behaves exactly like 2048, which toggles sclk on every running cycle. A freq_word of 0 never toggles sclk.
- R4: launch_en is high for exactly the one cycle after an sclk transition. It follows the rising transition (sclk becomes 1) when launch_rise is 1 and the falling transition when launch_rise is 0.
- R5: latch_en behaves the same way, with the transition direction chosen by latch_rise.
- R6: At an edge where loop_start and acc_rst_on_loop are both 1, the accumulator is cleared and no transition occurs. When acc_rst_on_loop is 0, loop_start has no effect.
- R7: At an edge where run is low, the internal phase is cleared and no strobe is issued, so sclk then equals cpol. The accumulator keeps its value while run is low.
- R8: sclk is the internal phase XOR cpol, so a change of cpol while idle shows on sclk without waiting for a clock edge.
- R9: rx_async_path and dbl_rate_mode equal rx_async_sel and dbl_rate_sel delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transfer active, from the sequencer |
| loop_start | input | 1 | Pulse at the start of each transfer loop |
| freq_word | input | 16 | Rate word, added per cycle (modulus 2048) |
| acc_rst_on_loop | input | 1 | Profile: clear the accumulator on loop_start |
| dbl_rate_sel | input | 1 | Profile: double-rate mode flag |
| launch_rise | input | 1 | Profile: launch on the rising transition (1) or the falling one (0) |
| latch_rise | input | 1 | Profile: latch on the rising transition (1) or the falling one (0) |
| rx_async_sel | input | 1 | Profile: use the asynchronous receive sampling path |
| cpol | input | 1 | Global clock polarity (idle level) |
| sclk | output | 1 | Serial clock |
| launch_en | output | 1 | One-cycle data launch enable |
| latch_en | output | 1 | One-cycle data latch enable |
| rx_async_path | output | 1 | Registered receive-path select |
| dbl_rate_mode | output | 1 | Registered double-rate flag |

## Verification
The assertions check on every cycle the relations that need no history. Idle forces sclk to the polarity level and suppresses both strobes. Each strobe coincides with a real sclk transition in the selected direction. A rate word at or above 2048 toggles sclk every cycle, a zero word or a loop clear gives no strobe, and the flags follow with one cycle of latency. The fractional cadence for intermediate words, the accumulator value held across idle gaps, and the difference between loop starts with and without clearing can only be shown by the bench's reference model and its directed transition counts.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  // Per-profile control bits as seen by the generator.
  typedef struct packed {
    logic acc_rst_on_loop;
    logic dbl_rate;
    logic launch_rise;
    logic latch_rise;
    logic rx_async;
  } spiclk_prof_t;

  localparam int unsigned FLAG_CNT = 2;
endpackage

// File: rtl/spiclk_rst_sync.sv
module spiclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spiclk_phase_accum.sv
module spiclk_phase_accum #(
  parameter int unsigned FREQ_W   = 16,
  parameter int unsigned MOD_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              loop_start,
  input  logic              rst_on_loop,
  input  logic [FREQ_W-1:0] freq_word,
  output logic              wrap
);
  localparam int unsigned MODULUS = 1 << MOD_LOG2;
  localparam int unsigned ACC_W   = MOD_LOG2;
  localparam int unsigned SUM_W   = MOD_LOG2 + 2;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] step, sum;
  logic             clear, acc_en, over;

  always_comb begin
    clear  = loop_start & rst_on_loop;
    step   = (freq_word > FREQ_W'(MODULUS)) ? SUM_W'(MODULUS) : SUM_W'(freq_word);
    sum    = {2'b00, acc_q} + step;
    over   = (sum >= SUM_W'(MODULUS));
    wrap   = run & ~clear & over;
    acc_en = run | clear;
    if (clear)     acc_d = '0;
    else if (over) acc_d = ACC_W'(sum - SUM_W'(MODULUS));
    else           acc_d = ACC_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/spiclk_edge_gen.sv
module spiclk_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wrap,
  input  logic cpol,
  input  logic launch_rise,
  input  logic latch_rise,
  output logic sclk,
  output logic launch_en,
  output logic latch_en
);
  logic ph_q, ph_d;
  logic launch_q, launch_d, latch_q, latch_d;
  logic lvl_d, moved;

  always_comb begin
    ph_d     = run ? (ph_q ^ wrap) : 1'b0;
    lvl_d    = ph_d ^ cpol;
    moved    = run & wrap;
    launch_d = moved & (lvl_d == launch_rise);
    latch_d  = moved & (lvl_d == latch_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= 1'b0;
      launch_q <= 1'b0;
      latch_q  <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      launch_q <= launch_d;
      latch_q  <= latch_d;
    end
  end

  assign sclk      = ph_q ^ cpol;
  assign launch_en = launch_q;
  assign latch_en  = latch_q;
endmodule

// File: rtl/spiclk_flag_regs.sv
module spiclk_flag_regs #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= d[i];
    end
    assign q[i] = f_q;
  end
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen #(
  parameter int unsigned FREQ_W   = 16,
  parameter int unsigned MOD_LOG2 = 11,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              loop_start,
  input  logic [FREQ_W-1:0] freq_word,
  input  logic              acc_rst_on_loop,
  input  logic              dbl_rate_sel,
  input  logic              launch_rise,
  input  logic              latch_rise,
  input  logic              rx_async_sel,
  input  logic              cpol,
  output logic              sclk,
  output logic              launch_en,
  output logic              latch_en,
  output logic              rx_async_path,
  output logic              dbl_rate_mode
);
  import spiclk_pkg::*;

  spiclk_prof_t                prof;
  logic                        rst_sync_n;
  logic                        wrap;
  logic [FLAG_CNT-1:0]         flags_d, flags_q;

  assign prof = '{acc_rst_on_loop: acc_rst_on_loop, dbl_rate: dbl_rate_sel,
                  launch_rise: launch_rise, latch_rise: latch_rise,
                  rx_async: rx_async_sel};

  spiclk_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  spiclk_phase_accum #(.FREQ_W(FREQ_W), .MOD_LOG2(MOD_LOG2)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .loop_start(loop_start),
    .rst_on_loop(prof.acc_rst_on_loop), .freq_word(freq_word), .wrap(wrap)
  );

  spiclk_edge_gen u_edge (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .wrap(wrap), .cpol(cpol),
    .launch_rise(prof.launch_rise), .latch_rise(prof.latch_rise),
    .sclk(sclk), .launch_en(launch_en), .latch_en(latch_en)
  );

  assign flags_d = {prof.dbl_rate, prof.rx_async};

  spiclk_flag_regs #(.N(FLAG_CNT)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .d(flags_d), .q(flags_q)
  );

  assign rx_async_path = flags_q[0];
  assign dbl_rate_mode = flags_q[1];
endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk #(
  parameter int unsigned FREQ_W   = 16,
  parameter int unsigned MOD_LOG2 = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              loop_start,
  input logic              acc_rst_on_loop,
  input logic [FREQ_W-1:0] freq_word,
  input logic              cpol,
  input logic              launch_rise,
  input logic              latch_rise,
  input logic              rx_async_sel,
  input logic              dbl_rate_sel,
  input logic              sclk,
  input logic              launch_en,
  input logic              latch_en,
  input logic              rx_async_path,
  input logic              dbl_rate_mode
);
  localparam logic [FREQ_W-1:0] FULL = FREQ_W'(1 << MOD_LOG2);

  // R7: an idle edge parks sclk at the polarity level with no strobes
  p_idle_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == cpol) && !launch_en && !latch_en);

  // R4: a launch strobe sits on a real transition in the chosen direction
  p_launch_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_en && $stable(cpol)) |-> (!$stable(sclk) && (sclk == $past(launch_rise))));

  // R5: same for the latch strobe
  p_latch_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && $stable(cpol)) |-> (!$stable(sclk) && (sclk == $past(latch_rise))));

  // R3: a full or larger rate word toggles on every running cycle
  p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && freq_word >= FULL && !(loop_start && acc_rst_on_loop))
      |=> (!$stable(cpol) || !$stable(sclk)));

  // R3: a zero rate word never produces a transition strobe
  p_zero_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && freq_word == '0) |=> (!launch_en && !latch_en));

  // R6: a clearing loop start produces no transition
  p_loop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_start && acc_rst_on_loop) |=> (!launch_en && !latch_en));

  // R9: flags follow their profile bits one edge later
  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_async_path == $past(rx_async_sel)) && (dbl_rate_mode == $past(dbl_rate_sel)));
endmodule

bind spiclk_gen spiclk_gen_chk #(.FREQ_W(FREQ_W), .MOD_LOG2(MOD_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .loop_start(loop_start),
  .acc_rst_on_loop(acc_rst_on_loop), .freq_word(freq_word), .cpol(cpol),
  .launch_rise(launch_rise), .latch_rise(latch_rise), .rx_async_sel(rx_async_sel),
  .dbl_rate_sel(dbl_rate_sel), .sclk(sclk), .launch_en(launch_en),
  .latch_en(latch_en), .rx_async_path(rx_async_path), .dbl_rate_mode(dbl_rate_mode)
);

// File: tb/spiclk_gen_bench.sv
`timescale 1ns/1ps
module spiclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, loop_start, acc_rst_on_loop, dbl_rate_sel;
  logic        launch_rise, latch_rise, rx_async_sel, cpol;
  logic [15:0] freq_word;
  logic        sclk, launch_en, latch_en, rx_async_path, dbl_rate_mode;

  int errors = 0;
  int checks = 0;
  int toggles = 0;
  logic prev_sclk;

  // reference model state
  int   m_acc;
  logic m_ph, m_launch, m_latch, m_async, m_dbl;

  always #5 clk = ~clk;

  spiclk_gen u_spiclk_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .loop_start(loop_start),
    .freq_word(freq_word), .acc_rst_on_loop(acc_rst_on_loop),
    .dbl_rate_sel(dbl_rate_sel), .launch_rise(launch_rise),
    .latch_rise(latch_rise), .rx_async_sel(rx_async_sel), .cpol(cpol),
    .sclk(sclk), .launch_en(launch_en), .latch_en(latch_en),
    .rx_async_path(rx_async_path), .dbl_rate_mode(dbl_rate_mode)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int step_of(input int f);
    return (f > 2048) ? 2048 : f;
  endfunction

  function automatic int exp_toggles(input int f, input int n);
    return (n * step_of(f)) / 2048;
  endfunction

  // advance the model by one edge using the current inputs
  task automatic model_edge();
    int   s;
    logic w, lvl;
    w = 1'b0;
    if (loop_start && acc_rst_on_loop) m_acc = 0;
    else if (run) begin
      s = m_acc + step_of(int'(freq_word));
      if (s >= 2048) begin w = 1'b1; s -= 2048; end
      m_acc = s;
    end
    m_ph     = run ? (m_ph ^ w) : 1'b0;
    lvl      = m_ph ^ cpol;
    m_launch = run && w && (lvl == launch_rise);
    m_latch  = run && w && (lvl == latch_rise);
    m_async  = rx_async_sel;
    m_dbl    = dbl_rate_sel;
  endtask

  // one clock: model step, edge, compare away from the edge
  task automatic cyc();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    if (sclk != prev_sclk) toggles++;
    prev_sclk = sclk;
    check(sclk == (m_ph ^ cpol), "R2 sclk", sclk, m_ph ^ cpol);
    check(launch_en == m_launch, "R4 launch_en", launch_en, m_launch);
    check(latch_en == m_latch, "R5 latch_en", latch_en, m_latch);
    check({dbl_rate_mode, rx_async_path} == {m_dbl, m_async}, "R9 flags",
          {dbl_rate_mode, rx_async_path}, {m_dbl, m_async});
  endtask

  task automatic go_idle(input int n);
    run = 1'b0; loop_start = 1'b0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  // clear accumulator via loop start, then run n cycles and count transitions
  task automatic run_count(input int f, input int n, input string tag);
    go_idle(1);
    freq_word = 16'(f); acc_rst_on_loop = 1'b1; run = 1'b1; loop_start = 1'b1;
    cyc();
    loop_start = 1'b0;
    toggles = 0;
    for (int i = 0; i < n; i++) cyc();
    check(toggles == exp_toggles(f, n), tag, toggles, exp_toggles(f, n));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seg_len, sel;
    logic t0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run = 1'b0; loop_start = 1'b0; freq_word = '0;
    acc_rst_on_loop = 1'b0; dbl_rate_sel = 1'b0; launch_rise = 1'b0;
    latch_rise = 1'b1; rx_async_sel = 1'b0; cpol = 1'b1;
    m_acc = 0; m_ph = 1'b0; m_launch = 1'b0; m_latch = 1'b0; m_async = 1'b0; m_dbl = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
    check({launch_en, latch_en, rx_async_path, dbl_rate_mode} == 4'b0,
          "R1 strobes/flags in reset", {launch_en, latch_en, rx_async_path, dbl_rate_mode}, 0);
    prev_sclk = sclk;
    rst_n = 1'b1;
    go_idle(4);

    // R3 / R2: transition counts from a cleared accumulator
    run_count(2048, 16, "R3 full rate");
    run_count(9000, 16, "R3 saturated word");
    run_count(0, 20, "R3 zero word");
    run_count(1024, 16, "R2 half rate");
    run_count(700, 30, "R2 fractional");
    launch_rise = 1'b1; latch_rise = 1'b0;
    run_count(1500, 25, "R2 fractional, R4/R5 swapped edges");

    // R7: accumulator held across idle; R6: loop start without clear
    run_count(1024, 3, "R2 prime");          // acc ends at 1024
    go_idle(3);
    check(sclk == cpol, "R7 idle level", sclk, cpol);
    acc_rst_on_loop = 1'b0; run = 1'b1; loop_start = 1'b1;
    t0 = sclk; cyc(); loop_start = 1'b0;
    check(sclk != t0, "R6 no clear, held acc wraps at once", sclk, !t0);
    // R6: clearing loop start suppresses the wrap
    run_count(1024, 1, "R2 prime2");          // acc ends at 1024
    go_idle(2);
    acc_rst_on_loop = 1'b1; run = 1'b1; loop_start = 1'b1;
    t0 = sclk; cyc(); loop_start = 1'b0;
    check(sclk == t0, "R6 clear, no transition", sclk, t0);
    cyc();
    check(sclk == t0, "R6 clear, 1024 after clear", sclk, t0);
    cyc();
    check(sclk != t0, "R6 clear, wrap on second add", sclk, !t0);

    // R8: polarity change while idle shows on sclk
    go_idle(1);
    cpol = ~cpol; #1;
    check(sclk == cpol, "R8 polarity follows", sclk, cpol);
    go_idle(1);
    // R9: flags
    rx_async_sel = 1'b1; dbl_rate_sel = 1'b1; cyc();
    check(rx_async_path && dbl_rate_mode, "R9 flags set", {dbl_rate_mode, rx_async_path}, 3);

    // constrained random segments
    for (int seg = 0; seg < 60; seg++) begin
      run = 1'b0; loop_start = 1'b0;
      cpol = 1'($urandom_range(0, 1));
      launch_rise = 1'($urandom_range(0, 1));
      latch_rise = 1'($urandom_range(0, 1));
      acc_rst_on_loop = 1'($urandom_range(0, 1));
      rx_async_sel = 1'($urandom_range(0, 1));
      dbl_rate_sel = 1'($urandom_range(0, 1));
      go_idle($urandom_range(1, 4));
      check(sclk == cpol, "R7 idle level random", sclk, cpol);
      sel = $urandom_range(0, 5);
      case (sel)
        0: freq_word = 16'd0;
        1: freq_word = 16'd2048;
        2: freq_word = 16'($urandom_range(2049, 65535));
        3: freq_word = 16'd1;
        default: freq_word = 16'($urandom_range(1, 2047));
      endcase
      seg_len = $urandom_range(20, 200);
      run = 1'b1;
      for (int i = 0; i < seg_len; i++) begin
        loop_start = ($urandom_range(0, 15) == 0);
        cyc();
      end
    end
    loop_start = 1'b0;
    go_idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule